// File: doc/BRIEF.md
# Coin-Operated Fruit Vending Controller

This block is a small clocked controller that sells a single fruit for a fixed price of 2€. A customer feeds coins through two separate inputs, one pulsed per 1€ coin and one pulsed per 0.50€ coin. The controller remembers how much has been paid so far by moving through a set of partial-payment states. Each state stands for one credit value, counted in half-euro units.

When the credit reaches exactly 2€, the fruit is released with a one-cycle dispense pulse. When the last coin pushes the credit past 2€, the controller first spends one cycle in a change-return state. That state pulses the change output and reports the excess amount. The dispense pulse follows in the next cycle. After dispensing, the credit is cleared and the controller waits for a new customer.

Next-state logic and per-state output decoding sit in separate modules around an enumerated state register.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, the controller is idle with zero credit: dispense_o, change_o and change_amt_o are all 0.
- R2: A cycle with coin_one_i high adds two half-euro units to the credit. A cycle with only coin_half_i high adds one unit. The credit becomes visible through the cycle in which the price is reached.
- R3: A cycle with both coin inputs low leaves the credit and state unchanged, so no output pulses.
- R4: When a coin brings the credit to exactly 4 units (2€), dispense_o is high in the cycle after that coin's clock edge, and change_o stays low.
- R5: When a coin brings the credit to 5 units, change_o is high for exactly one cycle after that coin's edge, with change_amt_o = 1 (one half-euro unit). dispense_o is high in the following cycle.
- R6: dispense_o is high for exactly one cycle. Afterwards the controller is idle with zero credit, so a new sale again needs a full 2€.
- R7: If coin_one_i and coin_half_i are high in the same cycle, only the 1€ coin is counted.
- R8: Coins presented during the change-return or dispense cycle are not counted.
- R9: dispense_o and change_o are never high together. change_amt_o is 0 whenever change_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_one_i | input | 1 | High for one cycle per 1€ coin |
| coin_half_i | input | 1 | High for one cycle per 0.50€ coin |
| dispense_o | output | 1 | One-cycle fruit release pulse |
| change_o | output | 1 | One-cycle change-return pulse |
| change_amt_o | output | AMT_W | Excess returned, in half-euro units, valid with change_o |

## Verification
The bench builds the controller with its default AMT_W of 2. The machine has only six states, so every reachable state can be visited with both coins presented in each of them. That covers every payment path to the price, and every path that overshoots it by one unit. The tests also cover the both-coins priority case, coins arriving during the change and dispense cycles, and long idle stretches inside a partial payment.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CREDIT_W = 3;
  localparam logic [CREDIT_W-1:0] PRICE_UNITS = 3'd4;
  localparam logic [CREDIT_W-1:0] BIG_UNITS   = 3'd2;
  localparam logic [CREDIT_W-1:0] SMALL_UNITS = 3'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALF,
    ST_ONE,
    ST_ONE_HALF,
    ST_CHANGE,
    ST_DISPENSE
  } vend_state_e;

  function automatic logic [CREDIT_W-1:0] credit_of(vend_state_e s);
    case (s)
      ST_HALF:     return 3'd1;
      ST_ONE:      return 3'd2;
      ST_ONE_HALF: return 3'd3;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic vend_state_e state_of(logic [CREDIT_W-1:0] c);
    case (c)
      3'd1:    return ST_HALF;
      3'd2:    return ST_ONE;
      3'd3:    return ST_ONE_HALF;
      default: return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  vend_state_e state_q,
  input  logic        coin_one_i,
  input  logic        coin_half_i,
  output vend_state_e state_d
);
  logic [CREDIT_W-1:0] add_units;
  logic [CREDIT_W-1:0] sum_units;

  // 1€ wins when both coins arrive together
  always_comb begin
    if (coin_one_i)       add_units = BIG_UNITS;
    else if (coin_half_i) add_units = SMALL_UNITS;
    else                  add_units = '0;
  end

  assign sum_units = credit_of(state_q) + add_units;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_HALF, ST_ONE, ST_ONE_HALF: begin
        if (sum_units == PRICE_UNITS)     state_d = ST_DISPENSE;
        else if (sum_units > PRICE_UNITS) state_d = ST_CHANGE;
        else                              state_d = state_of(sum_units);
      end
      ST_CHANGE:   state_d = ST_DISPENSE;
      ST_DISPENSE: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/vend_act.sv
module vend_act
  import vend_pkg::*;
#(
  parameter int AMT_W = 2
) (
  input  vend_state_e      state_q,
  output logic             dispense_o,
  output logic             change_o,
  output logic [AMT_W-1:0] change_amt_o
);
  localparam logic [AMT_W-1:0] EXCESS_UNITS = AMT_W'(1);

  always_comb begin
    dispense_o   = 1'b0;
    change_o     = 1'b0;
    change_amt_o = '0;
    case (state_q)
      ST_CHANGE: begin
        change_o     = 1'b1;
        change_amt_o = EXCESS_UNITS;
      end
      ST_DISPENSE: dispense_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int AMT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             coin_one_i,
  input  logic             coin_half_i,
  output logic             dispense_o,
  output logic             change_o,
  output logic [AMT_W-1:0] change_amt_o
);
  vend_state_e state_q;
  vend_state_e state_d;

  vend_next u_next (
    .state_q    (state_q),
    .coin_one_i (coin_one_i),
    .coin_half_i(coin_half_i),
    .state_d    (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  vend_act #(.AMT_W(AMT_W)) u_act (
    .state_q     (state_q),
    .dispense_o  (dispense_o),
    .change_o    (change_o),
    .change_amt_o(change_amt_o)
  );
endmodule

module vend_ctrl_chk
  import vend_pkg::*;
#(
  parameter int AMT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             coin_one_i,
  input logic             coin_half_i,
  input vend_state_e      state_q,
  input logic             dispense_o,
  input logic             change_o,
  input logic [AMT_W-1:0] change_amt_o
);
  AST_EXCLUSIVE_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dispense_o && change_o)); // R9
  AST_AMT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !change_o |-> change_amt_o == '0); // R9
  AST_CHANGE_AMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> change_amt_o == AMT_W'(1)); // R5
  AST_CHANGE_THEN_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |=> dispense_o && !change_o); // R5
  AST_DISP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispense_o |=> !dispense_o && !change_o && state_q == ST_IDLE); // R6
  AST_NO_COIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!coin_one_i && !coin_half_i && !dispense_o && !change_o) |=> $stable(state_q)); // R3
  AST_EXACT_PRICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ONE && coin_one_i) |=> dispense_o && !change_o); // R4
  AST_PRIORITY_BIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ONE_HALF && coin_one_i && coin_half_i) |=> change_o); // R7
  AST_SMALL_ADDS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && coin_half_i && !coin_one_i) |=> state_q == ST_HALF); // R2
endmodule

bind vend_ctrl vend_ctrl_chk #(.AMT_W(AMT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .coin_one_i  (coin_one_i),
  .coin_half_i (coin_half_i),
  .state_q     (state_q),
  .dispense_o  (dispense_o),
  .change_o    (change_o),
  .change_amt_o(change_amt_o)
);

// File: tb/vend_ctrl_tb.sv
`timescale 1ns/1ps
module vend_ctrl_tb;
  localparam int AMT_W = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             coin_one_i = 1'b0;
  logic             coin_half_i = 1'b0;
  logic             dispense_o;
  logic             change_o;
  logic [AMT_W-1:0] change_amt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: phase 0 collecting, 1 change, 2 dispense
  int m_credit = 0;
  int m_phase  = 0;

  always #2.5 clk = ~clk;

  vend_ctrl #(.AMT_W(AMT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .coin_one_i(coin_one_i), .coin_half_i(coin_half_i),
    .dispense_o(dispense_o), .change_o(change_o), .change_amt_o(change_amt_o)
  );

  task automatic model_step(input bit one, input bit half);
    int add;
    int sum;
    if (m_phase == 2) begin
      m_phase = 0; m_credit = 0;
    end else if (m_phase == 1) begin
      m_phase = 2;
    end else begin
      add = one ? 2 : (half ? 1 : 0);
      sum = m_credit + add;
      if (sum == 4)     begin m_phase = 2; m_credit = 0; end
      else if (sum > 4) begin m_phase = 1; m_credit = 0; end
      else              m_credit = sum;
    end
  endtask

  task automatic compare(input string tag);
    int exp_d;
    int exp_c;
    int exp_a;
    exp_d = (m_phase == 2) ? 1 : 0;
    exp_c = (m_phase == 1) ? 1 : 0;
    exp_a = (m_phase == 1) ? 1 : 0;
    checks++;
    if (int'(dispense_o) != exp_d || int'(change_o) != exp_c || int'(change_amt_o) != exp_a) begin
      fails++;
      $display("FAIL %s: disp=%0d chg=%0d amt=%0d expected disp=%0d chg=%0d amt=%0d",
               tag, dispense_o, change_o, change_amt_o, exp_d, exp_c, exp_a);
    end
  endtask

  // drive at negedge, clock in, compare at next negedge
  task automatic step(input bit one, input bit half, input string tag);
    coin_one_i  = one;
    coin_half_i = half;
    @(posedge clk);
    model_step(one, half);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    compare("R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    compare("R1 after release");
    step(0, 0, "R1 idle");
    // R4: 1€ + 1€ exact
    step(1, 0, "R2 one coin");
    step(0, 0, "R3 hold");
    step(0, 0, "R3 hold");
    step(1, 0, "R4 exact");
    step(0, 0, "R6 back to idle");
    // R2: four half coins
    for (int i = 0; i < 4; i++) step(0, 1, "R2 half coins");
    step(0, 0, "R6 idle");
    // R5: 0.50 + 0.50 + 0.50 + 1€ -> change then dispense
    step(0, 1, "R2 half");
    step(0, 1, "R2 half");
    step(0, 1, "R2 half");
    step(1, 0, "R5 overpay");
    step(0, 0, "R5 dispense after change");
    step(0, 0, "R6 idle");
    // R7: both at 1.50 counts as 1€ -> overpay
    step(1, 0, "R2 one");
    step(0, 1, "R2 half");
    step(1, 1, "R7 both at 1.50");
    // R8: coins during change and dispense ignored
    step(1, 1, "R8 during change");
    step(1, 0, "R8 during dispense");
    // R6: credit cleared; a single 1€ must not dispense
    step(1, 0, "R6 fresh credit");
    step(0, 0, "R6 no dispense");
    step(1, 1, "R7 both at 1.00 exact");
    step(0, 0, "R6 idle");
    // R7: both from idle counts 2 units only
    step(1, 1, "R7 both from idle");
    step(0, 1, "R7 half after both");
    step(0, 1, "R7 reaches price");
    step(0, 0, "R6 idle");
    // R3 long idle mid payment
    step(0, 1, "R2 half");
    for (int i = 0; i < 20; i++) step(0, 0, "R3 long hold");
    step(1, 0, "R2 to 1.50");
    step(0, 1, "R4 exact via half");
    step(0, 1, "R8 coin in dispense");
    step(0, 0, "R6 idle");
    // sweep: every coin from every collecting state
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 3; c++) begin
        for (int k = 0; k < s; k++) step(0, 1, "R2 sweep build");
        step(c == 0, c == 1, "R9 sweep coin");
        for (int k = 0; k < 3; k++) step(0, 0, "R9 sweep drain");
        rst_ni = 1'b0;
        m_phase = 0; m_credit = 0;
        @(negedge clk);
        compare("R1 mid reset");
        rst_ni = 1'b1;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule